// File: doc/BRIEF.md
# Flash Bad-Block Spare Remapper

The block translates logical flash block numbers into physical block numbers for an array that keeps a pool of reserved spare blocks. Normal translation never hands out a spare. A logical block maps to the physical block with the same number until the media back end reports that block as failed. At that point the remapper takes the next unused spare and issues a copy command, so the back end can move the failed block's valid contents into the spare. Only when the back end signals that the copy is complete does the remapper record the new mapping. Later accesses to that logical block are then steered to the spare.

Physical block numbers are `LBLK_W+1` bits wide. A most significant bit of 0 means the physical block equals the logical block. A most significant bit of 1 means the block is a spare, and the low `LBLK_W` bits hold the zero-extended spare index.

Requests arrive on a valid/ready port and answers leave on a one-entry valid/ready response port. A request is accepted only when all of the following hold:
- no copy is in progress;
- no fail report is waiting;
- the response slot is empty or is being drained in the same cycle.

A held response stalls further requests, which is the back-pressure rule. Fail reports use a valid/ready pair. The copy command uses a valid/ready pair followed by a single-cycle completion pulse. When the whole spare pool has been used, the block locks. In the locked state it refuses program and erase requests but still serves reads through the existing map, so the data can be backed up.

Top module: `spare_remapper`

## Requirements
- R1: After reset the status outputs are all low: `busy` is 0, `locked` is 0 and `spares_used` is 0. `copy_valid` and `rsp_valid` are also 0, while `req_ready` and `fail_ready` are 1. Every logical block maps to itself.
- R2: A logical block without a remap entry answers with physical block `{1'b0, lblk}`. No spare (MSB 1) is ever returned for such a block.
- R3: A request accepted at a clock edge presents `rsp_valid`, `rsp_pblk` and `rsp_reject` from that edge on. `rsp_valid` stays high with a stable `rsp_pblk` while `rsp_ready` is low, and `req_ready` is low during that time.
- R4: A fail report accepted while not locked raises `copy_valid` from the accepting edge. `copy_src` is the block's current physical mapping. `copy_dst` is `{1'b1, spares_used}`. Both are held until `copy_ready` is sampled high.
- R5: `busy` is high from the fail acceptance until the edge that samples `copy_done` in the wait phase. During that time `req_ready`, `fail_ready` and `rsp_valid` (for new requests) stay low.
- R6: The mapping and `spares_used` change only at the `copy_done` edge. From then on, requests for the failed block return the new spare, and `spares_used` has grown by exactly one.
- R7: Spares are assigned in increasing index order 0, 1, 2, and so on.
- R8: A failure reported for a block that is already remapped copies from its current spare into the next spare. The single table entry for that block is updated rather than duplicated, so afterwards only the new spare is returned for it, and other blocks keep their mappings.
- R9: `locked` is 1 exactly when `spares_used` equals `NUM_SPARES`. While locked, requests with `req_op` other than read (read = 2'b00; program = 2'b01, erase = 2'b10 and 2'b11 are write-class) respond with `rsp_reject` = 1. Reads respond with `rsp_reject` = 0 and the mapped block. Before the lock, no request is rejected.
- R10: While locked, a fail report is accepted (`fail_ready` = 1) and ignored: no copy command is issued, `busy` stays 0, and the map and `spares_used` do not change.
- R11: When `fail_valid` and `req_valid` are both high with no copy in progress, the fail report wins: `fail_ready` is 1 and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_lblk | input | LBLK_W | Logical block of the request |
| req_op | input | 2 | Operation: 00 read, 01 program, 10 erase, 11 write-class |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pblk | output | LBLK_W+1 | Translated physical block |
| rsp_reject | output | 1 | Request refused because the device is locked |
| fail_valid | input | 1 | Back end reports a failed block |
| fail_ready | output | 1 | Fail report accepted when high with `fail_valid` |
| fail_lblk | input | LBLK_W | Logical block that failed |
| copy_valid | output | 1 | Copy command present |
| copy_ready | input | 1 | Back end accepts the copy command |
| copy_src | output | LBLK_W+1 | Physical block to copy from |
| copy_dst | output | LBLK_W+1 | Spare block to copy into |
| copy_done | input | 1 | Copy finished; commits the mapping |
| busy | output | 1 | Replacement in progress |
| locked | output | 1 | Spare pool exhausted; writes refused |
| spares_used | output | $clog2(NUM_SPARES+1) | Count of consumed spares |

## Verification
A response is due one edge after the request is accepted. The copy command is due one edge after a fail report is accepted. The new mapping and the incremented spare count are due one edge after `copy_done` is sampled in the wait phase. The bench drives every input on a falling edge and samples on the next falling edge, so each result is read half a period after the single register it passes through. Between remaps, a sweep of every logical block with each operation is compared against a map that the bench keeps itself, so that untouched blocks, replaced blocks and the lock behaviour are all checked at the ports.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_WRX   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    CP_IDLE = 2'b00,
    CP_CMD  = 2'b01,
    CP_WAIT = 2'b10
  } cp_state_e;
endpackage

// File: rtl/remap_table.sv
module remap_table #(
  parameter int LBLK_W     = 8,
  parameter int NUM_SPARES = 16,
  parameter int SIDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LBLK_W-1:0] a_lblk,
  output logic              a_hit,
  output logic [SIDX_W-1:0] a_sidx,
  input  logic [LBLK_W-1:0] b_lblk,
  output logic              b_hit,
  output logic [SIDX_W-1:0] b_sidx,
  output logic [SIDX_W-1:0] b_slot,
  input  logic              wr_en,
  input  logic [SIDX_W-1:0] wr_slot,
  input  logic [LBLK_W-1:0] wr_lblk,
  input  logic [SIDX_W-1:0] wr_sidx
);
  logic              ent_v [NUM_SPARES];
  logic [LBLK_W-1:0] ent_l [NUM_SPARES];
  logic [SIDX_W-1:0] ent_s [NUM_SPARES];
  logic [NUM_SPARES-1:0] match_a, match_b;

  for (genvar g = 0; g < NUM_SPARES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[g] <= 1'b0;
        ent_l[g] <= '0;
        ent_s[g] <= '0;
      end else if (wr_en && wr_slot == SIDX_W'(g)) begin
        ent_v[g] <= 1'b1;
        ent_l[g] <= wr_lblk;
        ent_s[g] <= wr_sidx;
      end
    end
    assign match_a[g] = ent_v[g] && (ent_l[g] == a_lblk);
    assign match_b[g] = ent_v[g] && (ent_l[g] == b_lblk);
  end

  always_comb begin
    a_hit  = |match_a;
    a_sidx = '0;
    b_hit  = |match_b;
    b_sidx = '0;
    b_slot = '0;
    for (int i = 0; i < NUM_SPARES; i++) begin
      if (match_a[i]) a_sidx = ent_s[i];
      if (match_b[i]) begin
        b_sidx = ent_s[i];
        b_slot = SIDX_W'(i);
      end
    end
  end

  // R8: a logical block never owns more than one live entry
  assert_unique_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_a));
endmodule

// File: rtl/spare_alloc.sv
module spare_alloc #(
  parameter int NUM_SPARES = 16,
  parameter int SIDX_W     = 4,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  output logic [CNT_W-1:0]  count,
  output logic [SIDX_W-1:0] next_sidx,
  output logic              exhausted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (take && !exhausted) count <= count + 1'b1;
  end

  assign exhausted = (count == CNT_W'(NUM_SPARES));
  assign next_sidx = count[SIDX_W-1:0];

  // R9: the counter never passes the pool size
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(NUM_SPARES));
  // R7: spares are consumed one at a time, upward
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));
endmodule

// File: rtl/copy_seq.sv
module copy_seq
  import remap_pkg::*;
#(
  parameter int LBLK_W = 8,
  parameter int SIDX_W = 4,
  parameter int PBLK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PBLK_W-1:0] st_src,
  input  logic [PBLK_W-1:0] st_dst,
  input  logic [LBLK_W-1:0] st_lblk,
  input  logic [SIDX_W-1:0] st_slot,
  input  logic [SIDX_W-1:0] st_sidx,
  output logic              copy_valid,
  input  logic              copy_ready,
  output logic [PBLK_W-1:0] copy_src,
  output logic [PBLK_W-1:0] copy_dst,
  input  logic              copy_done,
  output logic              idle,
  output logic              commit,
  output logic [LBLK_W-1:0] cm_lblk,
  output logic [SIDX_W-1:0] cm_slot,
  output logic [SIDX_W-1:0] cm_sidx
);
  cp_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= CP_IDLE;
      copy_src <= '0;
      copy_dst <= '0;
      cm_lblk  <= '0;
      cm_slot  <= '0;
      cm_sidx  <= '0;
    end else begin
      case (st)
        CP_IDLE: if (start) begin
          st       <= CP_CMD;
          copy_src <= st_src;
          copy_dst <= st_dst;
          cm_lblk  <= st_lblk;
          cm_slot  <= st_slot;
          cm_sidx  <= st_sidx;
        end
        CP_CMD:  if (copy_ready) st <= CP_WAIT;
        CP_WAIT: if (copy_done)  st <= CP_IDLE;
        default: st <= CP_IDLE;
      endcase
    end
  end

  assign idle       = (st == CP_IDLE);
  assign copy_valid = (st == CP_CMD);
  assign commit     = (st == CP_WAIT) && copy_done;

  // R4: an offered copy command holds still until taken
  assert_cmd_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_valid && !copy_ready) |=> (copy_valid && $stable(copy_src) && $stable(copy_dst)));
  // R6: a commit only follows an accepted command
  assert_commit_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_valid && copy_ready) |=> !idle);
endmodule

// File: rtl/spare_remapper.sv
module spare_remapper
  import remap_pkg::*;
#(
  parameter int LBLK_W     = 8,
  parameter int NUM_SPARES = 16,
  localparam int SIDX_W    = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1,
  localparam int CNT_W     = $clog2(NUM_SPARES + 1),
  localparam int PBLK_W    = LBLK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LBLK_W-1:0] req_lblk,
  input  logic [1:0]        req_op,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PBLK_W-1:0] rsp_pblk,
  output logic              rsp_reject,
  input  logic              fail_valid,
  output logic              fail_ready,
  input  logic [LBLK_W-1:0] fail_lblk,
  output logic              copy_valid,
  input  logic              copy_ready,
  output logic [PBLK_W-1:0] copy_src,
  output logic [PBLK_W-1:0] copy_dst,
  input  logic              copy_done,
  output logic              busy,
  output logic              locked,
  output logic [CNT_W-1:0]  spares_used
);
  logic              a_hit, b_hit, seq_idle, commit, fail_go, req_fire, rsp_is_read;
  logic [SIDX_W-1:0] a_sidx, b_sidx, b_slot, next_sidx, cm_slot, cm_sidx;
  logic [LBLK_W-1:0] cm_lblk;
  logic [PBLK_W-1:0] a_pblk, b_pblk, new_pblk;

  remap_table #(.LBLK_W(LBLK_W), .NUM_SPARES(NUM_SPARES), .SIDX_W(SIDX_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .a_lblk(req_lblk), .a_hit(a_hit), .a_sidx(a_sidx),
    .b_lblk(fail_lblk), .b_hit(b_hit), .b_sidx(b_sidx), .b_slot(b_slot),
    .wr_en(commit), .wr_slot(cm_slot), .wr_lblk(cm_lblk), .wr_sidx(cm_sidx)
  );

  spare_alloc #(.NUM_SPARES(NUM_SPARES), .SIDX_W(SIDX_W), .CNT_W(CNT_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .take(commit),
    .count(spares_used), .next_sidx(next_sidx), .exhausted(locked)
  );

  assign a_pblk   = a_hit ? {1'b1, LBLK_W'(a_sidx)} : {1'b0, req_lblk};
  assign b_pblk   = b_hit ? {1'b1, LBLK_W'(b_sidx)} : {1'b0, fail_lblk};
  assign new_pblk = {1'b1, LBLK_W'(next_sidx)};

  assign fail_ready = seq_idle;
  assign fail_go    = fail_valid && seq_idle && !locked;
  assign req_ready  = seq_idle && !fail_valid && (!rsp_valid || rsp_ready);
  assign req_fire   = req_valid && req_ready;
  assign busy       = !seq_idle;

  copy_seq #(.LBLK_W(LBLK_W), .SIDX_W(SIDX_W), .PBLK_W(PBLK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(fail_go),
    .st_src(b_pblk), .st_dst(new_pblk), .st_lblk(fail_lblk),
    .st_slot(b_hit ? b_slot : next_sidx), .st_sidx(next_sidx),
    .copy_valid(copy_valid), .copy_ready(copy_ready),
    .copy_src(copy_src), .copy_dst(copy_dst), .copy_done(copy_done),
    .idle(seq_idle), .commit(commit),
    .cm_lblk(cm_lblk), .cm_slot(cm_slot), .cm_sidx(cm_sidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_pblk    <= '0;
      rsp_reject  <= 1'b0;
      rsp_is_read <= 1'b0;
    end else if (req_fire) begin
      rsp_valid   <= 1'b1;
      rsp_pblk    <= a_pblk;
      rsp_reject  <= locked && (req_op != OP_READ);
      rsp_is_read <= (req_op == OP_READ);
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  // R3: a stalled response keeps its value
  assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pblk) && $stable(rsp_reject)));
  // R9: reads are always served
  assert_read_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_is_read) |-> !rsp_reject);
  // R10: no copy is ever offered once the pool is exhausted
  assert_locked_no_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !copy_valid);
  // R5: no new response appears while a replacement is running
  assert_busy_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> !rsp_valid);
endmodule

// File: tb/sim_spare_remapper.sv
module sim_spare_remapper;
  localparam int LW = 4;
  localparam int NS = 4;
  localparam int NB = 1 << LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 1, fail_valid = 0, copy_ready = 0, copy_done = 0;
  logic [LW-1:0] req_lblk = '0, fail_lblk = '0;
  logic [1:0] req_op = 2'b00;
  logic req_ready, rsp_valid, rsp_reject, fail_ready, copy_valid, busy, locked;
  logic [LW:0] rsp_pblk, copy_src, copy_dst;
  logic [2:0] spares_used;

  int n_chk = 0, n_bad = 0;
  int mapv [NB];
  int used = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spare_remapper #(.LBLK_W(LW), .NUM_SPARES(NS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lblk(req_lblk), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pblk(rsp_pblk), .rsp_reject(rsp_reject),
    .fail_valid(fail_valid), .fail_ready(fail_ready), .fail_lblk(fail_lblk),
    .copy_valid(copy_valid), .copy_ready(copy_ready), .copy_src(copy_src), .copy_dst(copy_dst),
    .copy_done(copy_done), .busy(busy), .locked(locked), .spares_used(spares_used)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pblk(int l);
    return (mapv[l] >= 0) ? (NB + mapv[l]) : l;
  endfunction

  task automatic do_req(int l, int op);
    @(negedge clk);
    req_valid = 1; req_lblk = LW'(l); req_op = 2'(op);
    #1 chk("R3 req_ready idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    chk("R3 rsp_valid", int'(rsp_valid), 1);
    chk("R2/R6/R8 rsp_pblk", int'(rsp_pblk), exp_pblk(l));
    chk("R9 rsp_reject", int'(rsp_reject), (used == NS && op != 0) ? 1 : 0);
  endtask

  task automatic sweep();
    for (int l = 0; l < NB; l++)
      for (int op = 0; op < 4; op++) do_req(l, op);
  endtask

  task automatic do_fail(int l);
    bit was_locked = (used == NS);
    @(negedge clk);
    fail_valid = 1; fail_lblk = LW'(l);
    #1 chk("R11/R5 fail_ready", int'(fail_ready), 1);
    if (req_valid) chk("R11 req_ready low", int'(req_ready), 0);
    @(negedge clk);
    fail_valid = 0; req_valid = 0;
    if (was_locked) begin
      chk("R10 copy_valid", int'(copy_valid), 0);
      chk("R10 busy", int'(busy), 0);
      @(negedge clk);
      chk("R10 spares_used", int'(spares_used), used);
      return;
    end
    chk("R5 busy", int'(busy), 1);
    chk("R4 copy_valid", int'(copy_valid), 1);
    chk("R4/R8 copy_src", int'(copy_src), exp_pblk(l));
    chk("R4/R7 copy_dst", int'(copy_dst), NB + used);
    chk("R5 req_ready", int'(req_ready), 0);
    chk("R5 fail_ready", int'(fail_ready), 0);
    chk("R5 rsp_valid", int'(rsp_valid), 0);
    @(negedge clk);
    chk("R4 copy held", int'(copy_valid), 1);
    chk("R4 dst held", int'(copy_dst), NB + used);
    copy_ready = 1;
    @(negedge clk);
    copy_ready = 0;
    chk("R4 copy taken", int'(copy_valid), 0);
    chk("R6 still busy", int'(busy), 1);
    @(negedge clk);
    chk("R6 no early commit", int'(spares_used), used);
    copy_done = 1;
    @(negedge clk);
    copy_done = 0;
    mapv[l] = used;
    used++;
    chk("R5 busy cleared", int'(busy), 0);
    chk("R6 spares_used", int'(spares_used), used);
    chk("R9 locked", int'(locked), (used == NS) ? 1 : 0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) mapv[i] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 spares_used", int'(spares_used), 0);
    chk("R1 copy_valid", int'(copy_valid), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 fail_ready", int'(fail_ready), 1);
    sweep();
    req_valid = 1; req_lblk = 4'd2; req_op = 2'b00;   // R11 collision
    do_fail(5);
    sweep();
    do_fail(9);
    do_fail(5);                                        // R8 re-fail
    sweep();
    // R3 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_lblk = 4'd9; req_op = 2'b01;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R3 held valid", int'(rsp_valid), 1);
      chk("R3 held pblk", int'(rsp_pblk), exp_pblk(9));
      chk("R3 req_ready stalled", int'(req_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R3 drained", int'(rsp_valid), 0);
    do_fail(3);
    chk("R9 lock at pool size", int'(locked), 1);
    sweep();
    do_fail(7);                                        // R10 ignored
    sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule